// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Register Slave

This block sits on an 8-bit bus on which a microcontroller master first places an address and then data on the same lines. The master pulses an address strobe and the slave captures the address when that strobe falls. A read strobe, a write strobe and an active-low chip-enable then qualify the data phase. The slave owns a window of `NREG` byte registers starting at `BASE`. It accepts a write into the addressed register and, on a read, returns the register contents through a data-out bus and a separate output enable. The top level builds the tristate pad from these two signals.

The master on this bus toggles the address strobe all the time, including when no transfer takes place, so most captured addresses are junk. The slave keeps only the address captured most recently. It acts only when a read or write strobe arrives while that address lies in its window. The chip-enable line being low hands the bus to another device that shares it, and the slave stays silent then. All four control lines and the bus are brought into the clock domain through two-flop synchronizers, and edges are detected on the synchronized copies.

The highest register in the window is a doorbell. A write to it raises an interrupt request, and a completed read of it lowers that request again.

Top module: `mbus_periph`

## Requirements
- R1: After reset every register reads 0x00, `bus_oe` is low and `irq` is low.
- R2: The address is taken from `bus_in` at each falling edge of `ale`, and only the most recent one counts. A series of `ale` pulses with no read or write strobe changes no register and produces no bus drive.
- R3: A write with `ce_n` high to a latched address A, where BASE <= A <= BASE+NREG-1 (BASE+NREG must not exceed 256), stores into register A-BASE. The value stored is the last `bus_in` value sampled while `wr_n` was low, and it is committed after `wr_n` returns high. A change of `bus_in` after `wr_n` rises does not alter it.
- R4: `bus_oe` is high only while `rd_n` is low, `ce_n` is high and the latched address is in the window. It drops in the same instant that `rd_n` goes high, with no clock edge in between.
- R5: While `bus_oe` is high, `bus_out` equals the register at offset A-BASE and stays stable.
- R6: A read or write to an address outside the window produces no drive and alters no register.
- R7: A read or write made while `ce_n` is low produces no drive and alters no register.
- R8: A committed write to offset NREG-1 sets `irq`. `irq` stays high until a read of offset NREG-1 completes, that is, until `rd_n` rises. Writes and reads at other offsets leave `irq` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_in | input | 8 | Shared address/data lines as seen by the slave |
| ale | input | 1 | Address strobe; address captured on its falling edge |
| ce_n | input | 1 | Low: the other bus device is addressed; high: this slave may be |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| bus_out | output | 8 | Read data for the pad |
| bus_oe | output | 1 | Pad output enable |
| irq | output | 1 | Interrupt request, set by a doorbell write |

## Verification
The bench builds the block with BASE = 0xF8 and NREG = 8. With these values the window ends exactly at address 0xFF, so the sweep covers both edges of the window: the wrap at the top of the address space and the lower boundary at 0xF7. Because the address space has only 256 values, every address is written and then read back against an arithmetic model. These sweeps also pass through the doorbell at 0xFF. Directed sequences add long runs of junk address strobes and data that changes inside and just after the write strobe.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
    typedef logic [7:0] byte_t;

    typedef struct packed {
        logic  prev_ale;
        logic  prev_rd;
        logic  prev_wr;
        logic  wr_arm;
        byte_t wr_off;
        byte_t wr_data;
        logic  rd_act;
        byte_t rd_off;
        byte_t rd_data;
        logic  irq;
    } slv_state_t;
endpackage

// File: rtl/mbus_sync.sv
module mbus_sync #(
    parameter int         W    = 1,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= INIT;
            sync_q <= INIT;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;
endmodule

// File: rtl/mbus_decode.sv
module mbus_decode
    import mbus_pkg::*;
#(
    parameter byte_t BASE = 8'h40,
    parameter int    NREG = 8
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ale_fall,
    input  byte_t addr_in,
    output logic  hit,
    output byte_t off
);
    byte_t addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (ale_fall) addr_d = addr_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    assign off = addr_q - BASE;
    assign hit = (addr_q >= BASE) && ({24'd0, off} < NREG);
endmodule

// File: rtl/mbus_regfile.sv
module mbus_regfile
    import mbus_pkg::*;
#(
    parameter int NREG = 8,
    localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  byte_t         wdata,
    output byte_t         regs [NREG]
);
    byte_t regs_d [NREG];
    byte_t regs_q [NREG];

    always_comb begin
        for (int i = 0; i < NREG; i++) regs_d[i] = regs_q[i];
        if (we) regs_d[widx] = wdata;
    end

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) regs_q[g] <= '0;
                else        regs_q[g] <= regs_d[g];
            end
            assign regs[g] = regs_q[g];
        end
    endgenerate
endmodule

// File: rtl/mbus_periph.sv
module mbus_periph
    import mbus_pkg::*;
#(
    parameter byte_t BASE = 8'h40,
    parameter int    NREG = 8,
    localparam int   IW   = (NREG > 1) ? $clog2(NREG) : 1,
    localparam byte_t LAST = byte_t'(NREG - 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] bus_in,
    input  logic       ale,
    input  logic       ce_n,
    input  logic       rd_n,
    input  logic       wr_n,
    output logic [7:0] bus_out,
    output logic       bus_oe,
    output logic       irq
);
    // synchronized copies: {ale, ce_n, rd_n, wr_n, data}
    logic [11:0] s_vec;
    byte_t       s_data;
    logic        s_ale, s_ce_n, s_rd_n, s_wr_n;

    mbus_sync #(.W(12), .INIT(12'b0111_0000_0000)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({ale, ce_n, rd_n, wr_n, bus_in}),
        .q    (s_vec)
    );
    assign {s_ale, s_ce_n, s_rd_n, s_wr_n, s_data} = s_vec;

    slv_state_t st_d, st_q;
    logic       ale_fall, rd_fall, rd_rise, wr_rise;
    logic       hit, access_ok;
    byte_t      off;
    logic       reg_we;
    byte_t      regs [NREG];

    assign ale_fall = st_q.prev_ale & ~s_ale;
    assign rd_fall  = st_q.prev_rd  & ~s_rd_n;
    assign rd_rise  = ~st_q.prev_rd &  s_rd_n;
    assign wr_rise  = ~st_q.prev_wr &  s_wr_n;

    mbus_decode #(.BASE(BASE), .NREG(NREG)) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .ale_fall(ale_fall),
        .addr_in (s_data),
        .hit     (hit),
        .off     (off)
    );

    assign access_ok = hit & s_ce_n;

    always_comb begin
        st_d          = st_q;
        st_d.prev_ale = s_ale;
        st_d.prev_rd  = s_rd_n;
        st_d.prev_wr  = s_wr_n;
        reg_we        = 1'b0;

        // write phase: keep sampling data while strobe is low
        if (!s_wr_n && access_ok) begin
            st_d.wr_arm  = 1'b1;
            st_d.wr_off  = off;
            st_d.wr_data = s_data;
        end
        if (wr_rise) begin
            reg_we      = st_q.wr_arm;
            st_d.wr_arm = 1'b0;
            if (st_q.wr_arm && st_q.wr_off == LAST) st_d.irq = 1'b1;
        end

        // read phase
        if (rd_fall && access_ok) begin
            st_d.rd_act  = 1'b1;
            st_d.rd_off  = off;
            st_d.rd_data = regs[off[IW-1:0]];
        end
        if (rd_rise) begin
            st_d.rd_act = 1'b0;
            if (st_q.rd_act && st_q.rd_off == LAST) st_d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.prev_rd  <= 1'b1;
            st_q.prev_wr  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    mbus_regfile #(.NREG(NREG)) u_rf (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (reg_we),
        .widx (st_q.wr_off[IW-1:0]),
        .wdata(st_q.wr_data),
        .regs (regs)
    );

    // raw strobes gate the enable so release needs no clock edge
    assign bus_oe  = st_q.rd_act & ~rd_n & ce_n;
    assign bus_out = st_q.rd_data;
    assign irq     = st_q.irq;
endmodule

// File: rtl/mbus_periph_chk.sv
module mbus_periph_chk #(
    parameter int NREG = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_n,
    input logic       ce_n,
    input logic       bus_oe,
    input logic [7:0] bus_out,
    input logic       irq,
    input logic       we,
    input logic [7:0] wr_off,
    input logic [7:0] rd_off
);
    assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_n) |-> !bus_oe);

    assert_drive_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> ({24'd0, rd_off} < NREG));

    assert_ce_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> ce_n);

    assert_out_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && $past(bus_oe)) |-> $stable(bus_out));

    assert_write_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> ({24'd0, wr_off} < NREG));

    assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(we) && $past(wr_off) == 8'(NREG - 1)));
endmodule

bind mbus_periph mbus_periph_chk #(.NREG(NREG)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_n   (rd_n),
    .ce_n   (ce_n),
    .bus_oe (bus_oe),
    .bus_out(bus_out),
    .irq    (irq),
    .we     (reg_we),
    .wr_off (st_q.wr_off),
    .rd_off (st_q.rd_off)
);

// File: tb/mbus_periph_bench.sv
module mbus_periph_bench;
    localparam logic [7:0] BASE = 8'hF8;
    localparam int         NREG = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_in = 8'h00;
    logic       ale = 1'b0, ce_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [7:0] bus_out;
    logic       bus_oe, irq;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    logic [7:0] model [NREG];

    always #10 clk = ~clk;

    mbus_periph #(.BASE(BASE), .NREG(NREG)) u_mbus_periph (
        .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .ale(ale), .ce_n(ce_n),
        .rd_n(rd_n), .wr_n(wr_n), .bus_out(bus_out), .bus_oe(bus_oe), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic bit in_win(input logic [7:0] a);
        return (a >= BASE) && (int'(a) - int'(BASE) < NREG);
    endfunction

    task automatic latch(input logic [7:0] a);
        @(negedge clk); bus_in = a; ale = 1'b1;
        clks(3); ale = 1'b0;
        clks(3);
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d, input logic ce);
        latch(a);
        ce_n = ce; bus_in = d; wr_n = 1'b0;
        clks(4);
        wr_n = 1'b1; bus_in = ~d;
        clks(4);
        ce_n = 1'b1;
        if (ce && in_win(a)) model[a - BASE] = d;
    endtask

    task automatic do_read(input logic [7:0] a, input logic ce, input string req);
        bit exp_oe;
        latch(a);
        ce_n = ce; bus_in = 8'h3C; rd_n = 1'b0;
        exp_oe = ce && in_win(a);
        clks(5);
        check(bus_oe == exp_oe, req, bus_oe, exp_oe);
        if (exp_oe) check(bus_out == model[a - BASE], "R5", bus_out, model[a - BASE]);
        rd_n = 1'b1;
        #1 check(bus_oe == 1'b0, "R4 release", bus_oe, 0);
        clks(4);
        ce_n = 1'b1;
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) model[i] = 8'h00;
        clks(3);
        check(bus_oe == 1'b0 && irq == 1'b0, "R1 reset outputs", {bus_oe, irq}, 0);
        rst_n = 1'b1;
        clks(2);
        for (int i = 0; i < NREG; i++) do_read(BASE + 8'(i), 1'b1, "R1");

        // R3/R6: write sweep over the whole address space
        for (int a = 0; a < 256; a++) do_write(8'(a), 8'(a) ^ 8'hA5, 1'b1);
        check(irq == 1'b1, "R8 doorbell set", irq, 1);
        // R4/R6: read sweep; reading 0xFF clears irq
        for (int a = 0; a < 256; a++) do_read(8'(a), 1'b1, in_win(8'(a)) ? "R4" : "R6");
        check(irq == 1'b0, "R8 doorbell cleared", irq, 0);

        // R7: other device selected
        do_write(BASE + 8'd2, 8'h11, 1'b0);
        do_read(BASE + 8'd2, 1'b0, "R7");
        do_read(BASE + 8'd2, 1'b1, "R7 no write");

        // R2: junk address strobes override an in-window latch
        latch(BASE + 8'd1);
        for (int k = 0; k < 20; k++) latch(8'(k * 7));
        ce_n = 1'b1; rd_n = 1'b0; clks(5);
        check(bus_oe == 1'b0, "R2 last address rules", bus_oe, 0);
        rd_n = 1'b1; clks(4);
        // R2: junk in-window strobes alone write nothing
        for (int k = 0; k < 24; k++) latch(BASE + 8'(k % NREG));
        check(irq == 1'b0, "R2 no irq", irq, 0);
        for (int i = 0; i < NREG; i++) do_read(BASE + 8'(i), 1'b1, "R2 unchanged");

        // R3: data changes during the low phase, last value wins
        latch(BASE + 8'd3);
        bus_in = 8'h12; wr_n = 1'b0; clks(2);
        bus_in = 8'h9E; clks(4);
        wr_n = 1'b1; bus_in = 8'h00; clks(4);
        model[3] = 8'h9E;
        do_read(BASE + 8'd3, 1'b1, "R3 last sample");

        // R8: other writes leave irq alone; doorbell sets, other read keeps
        do_write(BASE, 8'h55, 1'b1);
        check(irq == 1'b0, "R8 other write", irq, 0);
        do_write(BASE + 8'(NREG - 1), 8'h77, 1'b1);
        check(irq == 1'b1, "R8 doorbell write", irq, 1);
        do_read(BASE, 1'b1, "R5");
        check(irq == 1'b1, "R8 other read", irq, 1);
        do_read(BASE + 8'(NREG - 1), 1'b1, "R5");
        check(irq == 1'b0, "R8 doorbell read", irq, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule